// File: doc/BRIEF.md
# Reloading Low-Pulse Width Timer

This block times the low phase of a PWM or infrared carrier waveform. Software programs an 8-bit preset and a prescaler ratio through a small register interface. A prescaler divides the timer clock into ticks, and each tick steps an 8-bit down-counter. When the counter passes zero, the block emits a one-cycle terminal-count strobe and reloads the preset by itself. A waveform generator can use that strobe to end its low phase. Each expiry also sets a pending flag. The flag drives the interrupt request, but only through an enable bit in an interrupt mask register.

The low phase lasts 2^code × (preset + 1) timer clocks, where code is the 3-bit prescaler select. A write to the preset while the counter is running changes only the period that starts at the next reload. A run-enable input freezes both the prescaler and the counter while it is low. The register map is: address 0 holds the preset, address 1 the prescaler control, address 2 the interrupt mask and address 3 the status.

Top module: `lpw_timer`

## Requirements
- R1: A synchronous reset clears the preset, the prescaler control, the mask register, the pending flag, the counter and the prescaler. During and after reset, `irq` and `tc_pulse` stay low until a tick occurs.
- R2: Reading address 0 returns all 8 preset bits as written, and reading address 2 returns all 8 mask bits. Reading address 1 returns the 3-bit prescaler code in bits 2:0, with bits 7:3 reading 0.
- R3: With prescaler code c (ratio 2^c) and preset P, successive `tc_pulse` strobes are exactly 2^c × (P+1) clock cycles apart while `run_en` is high.
- R4: A preset of 0 gives a period of exactly one prescaled tick, so code 0 with preset 0 strobes every cycle.
- R5: A preset written while the counter runs does not change the period in progress. It applies from the next reload onward.
- R6: `tc_pulse` is high for exactly one cycle per expiry when the period is longer than one cycle.
- R7: Status bit 0 (address 3) becomes 1 in the cycle after every expiry, whatever the mask, and it stays set until it is cleared.
- R8: `irq` equals the pending flag ANDed with mask bit 6. The other mask bits have no effect on `irq`.
- R9: Writing 1 to status bit 0 clears the pending flag, and writing 0 leaves it unchanged.
- R10: While `run_en` is low, no strobe occurs and the count freezes. The interval that contains a pause grows by exactly the number of cycles paused.
- R11: Any write to the prescaler control restarts the prescaler count, so the next tick comes 2^c cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counting enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt request |
| tc_pulse | output | 1 | One-cycle terminal-count strobe |

## Verification
The bench checks the degenerate period of one cycle (code 0, preset 0) and the longest period (code 7, preset 255). An off-by-one in the reload or in the prescaler limit would shift either interval by a whole tick. It rewrites the preset in the same edge as a reload. A design that loaded the counter from the new value, or that restarted mid-count, would shorten the current interval instead of the next one. It pauses `run_en` for 30 cycles and rewrites the prescaler control partway through a tick. Logic that kept counting, or that ignored the restart, would produce the strobe early. It also covers masks with every bit set except bit 6, and writes of 0 to the status register. Such stimulus would expose an interrupt decoded from the wrong mask bit, or a clear that triggers on any write.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    localparam int DATA_W      = 8;
    localparam int CODE_W      = 3;
    localparam int ADDR_W      = 2;
    localparam int MASK_EN_BIT = 6;
    localparam int PRE_W       = (1 << CODE_W) - 1;

    typedef enum logic [ADDR_W-1:0] {
        A_PRESET = 2'd0,
        A_CTRL   = 2'd1,
        A_MASK   = 2'd2,
        A_STAT   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [DATA_W-1:0] preset;
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] mask;
    } cfg_t;

    // terminal value of the prescaler count for a given select code
    function automatic logic [PRE_W-1:0] ratio_limit(input logic [CODE_W-1:0] c);
        logic [PRE_W:0] one_hot;
        one_hot = (PRE_W+1)'(1) << c;
        return PRE_W'(one_hot - (PRE_W+1)'(1));
    endfunction

endpackage

// File: rtl/lpw_regs.sv
module lpw_regs
    import lpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              pend_set,
    output cfg_t              cfg,
    output logic              pend,
    output logic              ctrl_wr,
    output logic              clr_req,
    output logic [DATA_W-1:0] rd_data
);

    reg_addr_e wsel;
    reg_addr_e rsel;

    assign wsel    = reg_addr_e'(wr_addr);
    assign rsel    = reg_addr_e'(rd_addr);
    assign ctrl_wr = wr_en && (wsel == A_CTRL);
    assign clr_req = wr_en && (wsel == A_STAT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wsel)
                A_PRESET: cfg.preset <= wr_data;
                A_CTRL:   cfg.code   <= wr_data[CODE_W-1:0];
                A_MASK:   cfg.mask   <= wr_data;
                default:  ;
            endcase
        end
    end

    // an expiry in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst)           pend <= 1'b0;
        else if (pend_set) pend <= 1'b1;
        else if (clr_req)  pend <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        case (rsel)
            A_PRESET: rd_data = cfg.preset;
            A_CTRL:   rd_data = DATA_W'(cfg.code);
            A_MASK:   rd_data = cfg.mask;
            A_STAT:   rd_data = DATA_W'(pend);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/lpw_prescaler.sv
module lpw_prescaler
    import lpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] lim;

    assign lim  = ratio_limit(code);
    assign tick = run_en && (pcnt == lim);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt <= '0;
        end else if (run_en) begin
            pcnt <= tick ? '0 : pcnt + PRE_W'(1);
        end
    end

endmodule

// File: rtl/lpw_counter.sv
module lpw_counter
    import lpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] preset,
    output logic              tc
);

    logic [DATA_W-1:0] cnt;

    assign tc = tick && (cnt == '0);

    // the preset is sampled only at the reload, never mid-count
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == '0) ? preset : cnt - DATA_W'(1);
        end
    end

endmodule

// File: rtl/lpw_timer.sv
module lpw_timer
    import lpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              tc_pulse
);

    cfg_t cfg_q;
    logic pend_q;
    logic ctrl_wr;
    logic clr_req;
    logic tick;
    logic lpw_en;

    lpw_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .pend_set (tc_pulse),
        .cfg      (cfg_q),
        .pend     (pend_q),
        .ctrl_wr  (ctrl_wr),
        .clr_req  (clr_req),
        .rd_data  (rd_data)
    );

    lpw_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .restart (ctrl_wr),
        .code    (cfg_q.code),
        .tick    (tick)
    );

    lpw_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .preset (cfg_q.preset),
        .tc     (tc_pulse)
    );

    assign lpw_en = cfg_q.mask[MASK_EN_BIT];
    assign irq    = pend_q & lpw_en;

endmodule

// File: rtl/lpw_timer_chk.sv
module lpw_timer_chk (
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic tc,
    input logic pend,
    input logic clr_req,
    input logic lpw_en,
    input logic irq
);

    AST_TC_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        tc |-> run_en); // R10

    AST_PEND_FROM_TC: assert property (@(posedge clk) disable iff (rst)
        tc |=> pend); // R7

    AST_PEND_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(tc)); // R7

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr_req) |=> pend); // R7

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !tc) |=> !pend); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !lpw_en |-> !irq); // R8

endmodule

bind lpw_timer lpw_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .tc      (tc_pulse),
    .pend    (pend_q),
    .clr_req (clr_req),
    .lpw_en  (lpw_en),
    .irq     (irq)
);

// File: tb/sim_lpw_timer.sv
module sim_lpw_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       run_en;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic       irq;
    logic       tc;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpw_timer u0 (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq      (irq),
        .tc_pulse (tc)
    );

    function automatic int period(int code, int p);
        return (1 << code) * (p + 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        wr_addr = 2'(a);
        wr_data = 8'(d);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        rd_addr = 2'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_tc(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tc && n < 40000);
    endtask

    // program, start, and measure one full period
    task automatic run_period(int code, int p, int m, string req);
        int n;
        int v;
        run_en = 1'b0;
        wr(1, code);
        wr(0, p);
        wr(2, m);
        wr(3, 1);
        run_en = 1'b1;
        wait_tc(n);
        wait_tc(n);
        chk(req, n, period(code, p));
        @(negedge clk);
        if (period(code, p) > 1) chk("R6 strobe width", int'(tc), 0);
        rd(3, v);
        chk("R7 pending after expiry", v, 1);
        chk("R8 irq follows mask bit 6", int'(irq), (m >> 6) & 1);
        run_en = 1'b0;
        wr(3, 0);
        rd(3, v);
        chk("R9 write 0 keeps pending", v, 1);
        wr(3, 1);
        rd(3, v);
        chk("R9 write 1 clears pending", v, 0);
        chk("R8 irq low after clear", int'(irq), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v;
        int n;
        int c;
        int p;
        int m;
        void'($urandom(32'd4711));
        rst = 1'b1; run_en = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        chk("R1 tc in reset", int'(tc), 0);
        rst = 1'b0;
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk("R1 register cleared", v, 0);
        end
        chk("R1 irq after reset", int'(irq), 0);

        wr(0, 8'hA5); rd(0, v); chk("R2 preset readback", v, 8'hA5);
        wr(0, 8'h5A); rd(0, v); chk("R2 preset readback", v, 8'h5A);
        wr(1, 8'hFF); rd(1, v); chk("R2 ctrl upper bits zero", v, 7);
        wr(2, 8'hC3); rd(2, v); chk("R2 mask readback", v, 8'hC3);
        wr(2, 8'h3C); rd(2, v); chk("R2 mask readback", v, 8'h3C);

        run_period(0, 0,   8'hBF, "R4 one-cycle period");
        run_period(7, 0,   8'h40, "R4 one-tick period");
        run_period(0, 255, 8'hFF, "R3 full preset");
        run_period(7, 255, 8'h00, "R3 longest period");
        for (int i = 0; i < 12; i++) begin
            c = int'($urandom % 4);
            p = int'($urandom % 32);
            m = int'($urandom % 256);
            run_period(c, p, m, "R3 random period");
        end

        // R5: preset rewritten at a reload edge
        run_en = 1'b0; wr(1, 1); wr(0, 3); run_en = 1'b1;
        wait_tc(n); wait_tc(n);
        wr(0, 9);
        wait_tc(n); chk("R5 current period keeps old preset", n, period(1, 3) - 1);
        wait_tc(n); chk("R5 next period uses new preset", n, period(1, 9));

        // R10: pause of 30 cycles
        run_en = 1'b0; wr(0, 4); run_en = 1'b1;
        wait_tc(n); wait_tc(n);
        @(negedge clk);
        run_en = 1'b0;
        v = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            v += int'(tc);
        end
        chk("R10 no strobe while paused", v, 0);
        run_en = 1'b1;
        wait_tc(n); chk("R10 interval stretched by pause", n, period(1, 4) - 1);

        // R11: prescaler restart by control write
        run_en = 1'b0; wr(1, 3); wr(0, 0); run_en = 1'b1;
        wait_tc(n); wait_tc(n);
        chk("R3 ratio 8 period", n, 8);
        repeat (3) @(negedge clk);
        wr(1, 3);
        wait_tc(n); chk("R11 restart delays tick", n, 7);

        // R1: reset after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_en = 1'b0;
        rd(0, v); chk("R1 preset cleared", v, 0);
        rd(2, v); chk("R1 mask cleared", v, 0);
        rd(3, v); chk("R1 pending cleared", v, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule